// File: doc/BRIEF.md
# BCD Real-Time Clock Register Bank

This block keeps calendar time in packed BCD: seconds, minutes, 24-hour hours, weekday, day of month, month, two-digit year and century. The count moves forward by one second on every cycle in which the `tick` input is high, for example a 1 Hz enable, unless the stop bit is set. A host reaches sixteen byte-wide registers through a simple byte bus. The registers occupy the highest sixteen addresses of a window of `2**ADDR_W` bytes. Addresses below the register window are not decoded by this block and read back as zero.

The host reads and sets the time through two hold bits in the flags register.
- The read-hold bit freezes a visible copy of the time, so that a read of several bytes is coherent.
- The write-hold bit lets the host stage a complete new time in that copy. The staged time is loaded into the running counters when the bit is cleared.

An alarm comparator checks the seconds, minutes, hours and date fields after every advance. Each field can be masked. A match sets a sticky alarm flag, and reading the flags register clears it. The interrupt output is high while both the flag and its enable are set.

Top module: `rtc_regbank`

## Requirements
- R1: Register offsets within the window are: 0 flags, 1 century, 2 seconds alarm, 3 minutes alarm, 4 hours alarm, 5 date alarm, 6 interrupt enable, 7 watchdog, 8 calibration, 9 seconds, 10 minutes, 11 hours, 12 weekday, 13 date, 14 month, 15 year. The window begins at address `2**ADDR_W-16`, and a read of any address below it returns 0x00. After reset the following values read back:
  - flags, interrupt enable and calibration: 0x00;
  - time: century 0x20, year 0x00, month 0x01, date 0x01, weekday 0x01, and 0x00 for hours, minutes and seconds.
- R2: Each tick with the stop bit clear advances the time by one second in BCD. Seconds and minutes run from 00 to 59, and hours run from 00 to 23. At each change of day the weekday steps from 1 to 7 and then wraps to 1.
- R3: The date rolls over after the last day of the month. April, June, September and November have 30 days, February has 28 or 29 days, and all other months have 31. A leap year is one whose full year is divisible by 4, except years divisible by 100 that are not divisible by 400. A year rollover from 99 to 00 increments the century.
- R4: Writing flags bit 0 as 1 freezes the visible time registers while ticks continue to advance the counters. Writing it as 0 lets the visible registers follow the counters again.
- R5: The following rules govern time writes:
  - While flags bit 1 is 1, writes to time registers update only the staged copy. Seconds keep bits 6:0 and weekday keeps bits 2:0.
  - Writing bit 1 back to 0 loads the staged time into the counters, and any tick in that cycle is lost.
  - A time-register write made while bit 1 is 0 is ignored.
- R6: Calibration bit 7 is the stop bit, and while it is set ticks do not advance the time. Calibration bits 5:0 read back as written, and bit 6 reads as 0.
- R7: In each alarm register, bit 7 set masks that field, and bits 6:0 are otherwise compared with the field. After each advance the new time is compared. If all unmasked fields are equal, flags bit 6 (the alarm flag) is set. With all four fields masked, every tick sets the flag.
- R8: A read of the flags register returns the alarm flag in bit 6 and then clears it. If an alarm match occurs in the same cycle as that read, the read returns the old flag value and the flag stays set.
- R9: The `irq` output is high exactly while the alarm flag and interrupt-enable bit 6 are both 1. Interrupt-enable bit 6 reads back in bit 6, and its other bits read as 0.
- R10: Flags bit 5 shows the level of the `pwr_fail` input. The watchdog register is plain 8-bit read/write storage.
- R11: `rdata` is updated at the clock edge that samples `rd`, and holds its value while `rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-second advance enable |
| addr | input | ADDR_W | Byte address in the window |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe, one cycle per byte |
| rd | input | 1 | Read strobe, one cycle per byte |
| rdata | output | 8 | Registered read data |
| pwr_fail | input | 1 | Power-fail level, shown in flags bit 5 |
| irq | output | 1 | Alarm interrupt |

## Verification
Two functions can fall in the same cycle: a flags read, which clears the alarm flag, and a tick whose new time matches the alarm, which sets it. The bench masks all four alarm fields so that every tick matches. It then raises `rd` on the flags address and `tick` in the same cycle. It expects that read to return bit 6 as 0, and a following flags read to return 0x40. A second collision is also exercised: clearing the write-hold bit while a tick is pending must load the staged seconds value unchanged.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NUM_REGS = 16;
    localparam int REG_AW   = $clog2(NUM_REGS);
    localparam int ALM_FIELDS = 4;
    localparam int ALM_CMP_W  = 7;

    typedef enum logic [REG_AW-1:0] {
        REG_FLAGS    = 4'd0,
        REG_CEN      = 4'd1,
        REG_ALM_SEC  = 4'd2,
        REG_ALM_MIN  = 4'd3,
        REG_ALM_HR   = 4'd4,
        REG_ALM_DATE = 4'd5,
        REG_IRQ_EN   = 4'd6,
        REG_WDOG     = 4'd7,
        REG_CAL      = 4'd8,
        REG_SEC      = 4'd9,
        REG_MIN      = 4'd10,
        REG_HR       = 4'd11,
        REG_WDAY     = 4'd12,
        REG_DATE     = 4'd13,
        REG_MON      = 4'd14,
        REG_YR       = 4'd15
    } reg_off_e;

    typedef struct packed {
        logic [7:0] cen;
        logic [7:0] yr;
        logic [7:0] mon;
        logic [7:0] date;
        logic [7:0] wday;
        logic [7:0] hr;
        logic [7:0] min;
        logic [7:0] sec;
    } rtc_time_t;

    typedef struct packed {
        rtc_time_t  cnt;
        rtc_time_t  vis;
        logic       hold_rd;
        logic       hold_wr;
        logic       af;
        logic [7:0] alm_sec;
        logic [7:0] alm_min;
        logic [7:0] alm_hr;
        logic [7:0] alm_date;
        logic       aie;
        logic [7:0] wdog;
        logic       stop;
        logic [5:0] cal;
        logic [7:0] rdata;
    } bank_t;

    // Increment a two-digit packed BCD value (no wrap handling)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Two BCD digits divisible by four: depends on tens parity and units
    function automatic logic bcd_div4(input logic [7:0] v);
        if (v[4]) return (v[3:0] == 4'd2) || (v[3:0] == 4'd6);
        else      return (v[3:0] == 4'd0) || (v[3:0] == 4'd4) || (v[3:0] == 4'd8);
    endfunction

    function automatic logic bcd_leap(input logic [7:0] cen, input logic [7:0] yr);
        if (yr == 8'h00) return bcd_div4(cen);
        else             return bcd_div4(yr);
    endfunction

    function automatic logic [7:0] bcd_last_day(input logic [7:0] mon,
                                                input logic [7:0] cen,
                                                input logic [7:0] yr);
        case (mon)
            8'h02:                      return bcd_leap(cen, yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  rtc_time_t now,
    output rtc_time_t nxt
);

    logic [7:0] last_day;

    always_comb begin
        last_day = bcd_last_day(now.mon, now.cen, now.yr);
        nxt = now;
        if (now.sec >= 8'h59) begin
            nxt.sec = 8'h00;
            if (now.min >= 8'h59) begin
                nxt.min = 8'h00;
                if (now.hr >= 8'h23) begin
                    nxt.hr   = 8'h00;
                    nxt.wday = (now.wday >= 8'h07) ? 8'h01 : bcd_inc(now.wday);
                    if (now.date >= last_day) begin
                        nxt.date = 8'h01;
                        if (now.mon >= 8'h12) begin
                            nxt.mon = 8'h01;
                            if (now.yr >= 8'h99) begin
                                nxt.yr  = 8'h00;
                                nxt.cen = bcd_inc(now.cen);
                            end else begin
                                nxt.yr = bcd_inc(now.yr);
                            end
                        end else begin
                            nxt.mon = bcd_inc(now.mon);
                        end
                    end else begin
                        nxt.date = bcd_inc(now.date);
                    end
                end else begin
                    nxt.hr = bcd_inc(now.hr);
                end
            end else begin
                nxt.min = bcd_inc(now.min);
            end
        end else begin
            nxt.sec = bcd_inc(now.sec);
        end
    end

endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
    parameter int NFIELDS = 4,
    parameter int CMP_W   = 7
) (
    input  logic [NFIELDS*(CMP_W+1)-1:0] alm,
    input  logic [NFIELDS*CMP_W-1:0]     cur,
    output logic                         hit
);

    localparam int FW = CMP_W + 1;

    logic [NFIELDS-1:0] field_ok;

    for (genvar i = 0; i < NFIELDS; i++) begin : g_field
        // top bit of each alarm byte is the don't-care mask
        assign field_ok[i] = alm[i*FW+CMP_W] ||
                             (alm[i*FW +: CMP_W] == cur[i*CMP_W +: CMP_W]);
    end

    assign hit = &field_ok;

endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
    import rtc_pkg::*;
#(
    parameter int         ADDR_W       = 17,
    parameter logic [7:0] INIT_CENTURY = 8'h20,
    parameter logic [7:0] INIT_YEAR    = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [7:0]        rdata,
    input  logic              pwr_fail,
    output logic              irq
);

    localparam rtc_time_t INIT_TIME = '{cen: INIT_CENTURY, yr: INIT_YEAR,
                                        mon: 8'h01, date: 8'h01, wday: 8'h01,
                                        hr: 8'h00, min: 8'h00, sec: 8'h00};

    bank_t     q, d;
    rtc_time_t tm_adv;
    logic      adv;
    logic      alarm_hit;
    logic      sel;
    reg_off_e  off;
    logic      flags_wr;
    logic      flags_rd;
    logic [7:0] rd_val;

    assign sel      = (addr[ADDR_W-1:REG_AW] == '1);
    assign off      = reg_off_e'(addr[REG_AW-1:0]);
    assign flags_wr = wr && sel && (off == REG_FLAGS);
    assign flags_rd = rd && sel && (off == REG_FLAGS);
    assign adv      = tick && !q.stop;

    rtc_calendar u_cal (
        .now (q.cnt),
        .nxt (tm_adv)
    );

    rtc_alarm_match #(
        .NFIELDS (ALM_FIELDS),
        .CMP_W   (ALM_CMP_W)
    ) u_alm (
        .alm ({q.alm_date, q.alm_hr, q.alm_min, q.alm_sec}),
        .cur ({tm_adv.date[6:0], tm_adv.hr[6:0], tm_adv.min[6:0], tm_adv.sec[6:0]}),
        .hit (alarm_hit)
    );

    // read multiplexer
    always_comb begin
        case (off)
            REG_FLAGS:    rd_val = {1'b0, q.af, pwr_fail, 3'b000, q.hold_wr, q.hold_rd};
            REG_CEN:      rd_val = q.vis.cen;
            REG_ALM_SEC:  rd_val = q.alm_sec;
            REG_ALM_MIN:  rd_val = q.alm_min;
            REG_ALM_HR:   rd_val = q.alm_hr;
            REG_ALM_DATE: rd_val = q.alm_date;
            REG_IRQ_EN:   rd_val = {1'b0, q.aie, 6'b000000};
            REG_WDOG:     rd_val = q.wdog;
            REG_CAL:      rd_val = {q.stop, 1'b0, q.cal};
            REG_SEC:      rd_val = q.vis.sec;
            REG_MIN:      rd_val = q.vis.min;
            REG_HR:       rd_val = q.vis.hr;
            REG_WDAY:     rd_val = q.vis.wday;
            REG_DATE:     rd_val = q.vis.date;
            REG_MON:      rd_val = q.vis.mon;
            REG_YR:       rd_val = q.vis.yr;
            default:      rd_val = 8'h00;
        endcase
    end

    // next-state logic
    always_comb begin
        d = q;

        if (adv) d.cnt = tm_adv;

        if (!(q.hold_rd || q.hold_wr)) d.vis = q.cnt;

        d.af = alarm_hit && adv ? 1'b1 : (q.af && !flags_rd);

        if (rd) d.rdata = sel ? rd_val : 8'h00;

        if (wr && sel) begin
            case (off)
                REG_FLAGS: begin
                    d.hold_rd = wdata[0];
                    d.hold_wr = wdata[1];
                    if (q.hold_wr && !wdata[1]) d.cnt = q.vis;
                end
                REG_ALM_SEC:  d.alm_sec  = wdata;
                REG_ALM_MIN:  d.alm_min  = wdata;
                REG_ALM_HR:   d.alm_hr   = wdata;
                REG_ALM_DATE: d.alm_date = wdata;
                REG_IRQ_EN:   d.aie      = wdata[6];
                REG_WDOG:     d.wdog     = wdata;
                REG_CAL: begin
                    d.stop = wdata[7];
                    d.cal  = wdata[5:0];
                end
                REG_CEN:  if (q.hold_wr) d.vis.cen  = wdata;
                REG_SEC:  if (q.hold_wr) d.vis.sec  = {1'b0, wdata[6:0]};
                REG_MIN:  if (q.hold_wr) d.vis.min  = wdata;
                REG_HR:   if (q.hold_wr) d.vis.hr   = wdata;
                REG_WDAY: if (q.hold_wr) d.vis.wday = {5'b00000, wdata[2:0]};
                REG_DATE: if (q.hold_wr) d.vis.date = wdata;
                REG_MON:  if (q.hold_wr) d.vis.mon  = wdata;
                REG_YR:   if (q.hold_wr) d.vis.yr   = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q          <= '0;
            q.cnt      <= INIT_TIME;
            q.vis      <= INIT_TIME;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.rdata;
    assign irq   = q.af && q.aie;

    // R6
    stop_freezes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.stop && !flags_wr) |=> $stable(q.cnt));

    // R7
    alarm_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.af) |-> $past(tick));

    // R8
    flags_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_rd && !alarm_hit) |=> !q.af);

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> $stable(rdata));

    // R4
    freeze_holds_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.hold_rd && !q.hold_wr) |=> $stable(q.vis));

endmodule

// File: tb/rtc_regbank_test.sv
module rtc_regbank_test;

    localparam int ADDR_W = 17;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'((1 << ADDR_W) - 16);

    typedef struct {
        int c, y, mo, d, wd, h, mi, s;
    } tm_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tick = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0]        wdata = 8'h00;
    logic              wr = 1'b0;
    logic              rd = 1'b0;
    logic [7:0]        rdata;
    logic              pwr_fail = 1'b0;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    rtc_regbank #(.ADDR_W(ADDR_W)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .addr     (addr),
        .wdata    (wdata),
        .wr       (wr),
        .rd       (rd),
        .rdata    (rdata),
        .pwr_fail (pwr_fail),
        .irq      (irq)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] to_bcd(input int n);
        return 8'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic bit is_leap(input int c, input int y);
        int full;
        full = c * 100 + y;
        return ((full % 4 == 0) && (full % 100 != 0)) || (full % 400 == 0);
    endfunction

    function automatic int days_in(input int c, input int y, input int mo);
        if (mo == 2) return is_leap(c, y) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic tm_t next_sec(input tm_t t);
        tm_t n;
        n = t;
        n.s = t.s + 1;
        if (n.s == 60) begin
            n.s = 0; n.mi = t.mi + 1;
            if (n.mi == 60) begin
                n.mi = 0; n.h = t.h + 1;
                if (n.h == 24) begin
                    n.h = 0;
                    n.wd = (t.wd == 7) ? 1 : t.wd + 1;
                    n.d = t.d + 1;
                    if (n.d > days_in(t.c, t.y, t.mo)) begin
                        n.d = 1; n.mo = t.mo + 1;
                        if (n.mo == 13) begin
                            n.mo = 1; n.y = t.y + 1;
                            if (n.y == 100) begin
                                n.y = 0; n.c = t.c + 1;
                            end
                        end
                    end
                end
            end
        end
        return n;
    endfunction

    function automatic logic [63:0] pack_tm(input tm_t t);
        return {to_bcd(t.c), to_bcd(t.y), to_bcd(t.mo), to_bcd(t.d),
                to_bcd(t.wd), to_bcd(t.h), to_bcd(t.mi), to_bcd(t.s)};
    endfunction

    function automatic tm_t mk(input int c, input int y, input int mo, input int d,
                               input int wd, input int h, input int mi, input int s);
        tm_t t;
        t.c = c; t.y = y; t.mo = mo; t.d = d; t.wd = wd; t.h = h; t.mi = mi; t.s = s;
        return t;
    endfunction

    task automatic write_reg(input int off, input logic [7:0] v);
        @(negedge clk);
        addr = BASE + ADDR_W'(off); wdata = v; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic read_addr(input logic [ADDR_W-1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic read_reg(input int off, output logic [7:0] v);
        read_addr(BASE + ADDR_W'(off), v);
    endtask

    task automatic do_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_time(input tm_t t);
        write_reg(0, 8'h02);
        write_reg(1, to_bcd(t.c));
        write_reg(15, to_bcd(t.y));
        write_reg(14, to_bcd(t.mo));
        write_reg(13, to_bcd(t.d));
        write_reg(12, to_bcd(t.wd));
        write_reg(11, to_bcd(t.h));
        write_reg(10, to_bcd(t.mi));
        write_reg(9, to_bcd(t.s));
        write_reg(0, 8'h00);
    endtask

    task automatic read_time(output tm_t t);
        logic [7:0] v;
        write_reg(0, 8'h01);
        read_reg(1, v);  t.c  = from_bcd(v);
        read_reg(15, v); t.y  = from_bcd(v);
        read_reg(14, v); t.mo = from_bcd(v);
        read_reg(13, v); t.d  = from_bcd(v);
        read_reg(12, v); t.wd = from_bcd(v);
        read_reg(11, v); t.h  = from_bcd(v);
        read_reg(10, v); t.mi = from_bcd(v);
        read_reg(9, v);  t.s  = from_bcd(v);
        write_reg(0, 8'h00);
    endtask

    task automatic check_time(input string tag, input tm_t exp);
        tm_t got;
        read_time(got);
        check(pack_tm(got) == pack_tm(exp), tag, pack_tm(got), pack_tm(exp));
    endtask

    task automatic roll_case(input string tag, input tm_t t);
        set_time(t);
        do_tick();
        check_time(tag, next_sec(t));
    endtask

    initial begin
        logic [7:0] v;
        tm_t t;
        tm_t t0;
        void'($urandom(32'd1357));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state and window decode
        read_reg(0, v);  check(v == 8'h00, "R1 flags reset", 64'(v), 64'h00);
        read_reg(6, v);  check(v == 8'h00, "R1 irq enable reset", 64'(v), 64'h00);
        read_reg(8, v);  check(v == 8'h00, "R1 calibration reset", 64'(v), 64'h00);
        check_time("R1 reset time", mk(20, 0, 1, 1, 1, 0, 0, 0));
        write_reg(7, 8'h5A);
        read_addr(BASE - ADDR_W'(9), v);
        check(v == 8'h00, "R1 below window reads zero", 64'(v), 64'h00);

        // R2 rollover through day, weekday wrap
        t = mk(20, 24, 12, 31, 7, 23, 59, 58);
        set_time(t);
        do_tick(); do_tick();
        check_time("R2 new year double tick", next_sec(next_sec(t)));
        roll_case("R2 minute carry", mk(20, 25, 6, 10, 3, 14, 59, 59));
        roll_case("R2 hour carry weekday", mk(20, 25, 6, 10, 3, 23, 59, 59));

        // R3 month lengths and leap years
        roll_case("R3 feb 2023", mk(20, 23, 2, 28, 2, 23, 59, 59));
        roll_case("R3 feb 2024", mk(20, 24, 2, 28, 3, 23, 59, 59));
        roll_case("R3 feb 2024 last", mk(20, 24, 2, 29, 4, 23, 59, 59));
        roll_case("R3 feb 2100", mk(21, 0, 2, 28, 7, 23, 59, 59));
        roll_case("R3 feb 2000", mk(20, 0, 2, 28, 1, 23, 59, 59));
        roll_case("R3 april 30", mk(20, 25, 4, 30, 5, 23, 59, 59));
        roll_case("R3 century carry", mk(20, 99, 12, 31, 4, 23, 59, 59));

        // R2 R3 random times with biased rollovers
        for (int i = 0; i < 40; i++) begin
            tm_t r;
            r.c  = 19 + int'($urandom % 3);
            r.y  = int'($urandom % 100);
            r.mo = 1 + int'($urandom % 12);
            r.wd = 1 + int'($urandom % 7);
            if ($urandom % 2 == 0) begin
                r.d = days_in(r.c, r.y, r.mo); r.h = 23; r.mi = 59; r.s = 59;
            end else begin
                r.d  = 1 + int'($urandom % days_in(r.c, r.y, r.mo));
                r.h  = int'($urandom % 24);
                r.mi = int'($urandom % 60);
                r.s  = int'($urandom % 60);
            end
            roll_case("R2 R3 random tick", r);
        end

        // R4 read freeze
        t0 = mk(20, 25, 3, 14, 5, 9, 26, 53);
        set_time(t0);
        write_reg(0, 8'h01);
        do_tick(); do_tick(); do_tick();
        read_reg(9, v);  check(v == 8'h53, "R4 frozen seconds", 64'(v), 64'h53);
        read_reg(10, v); check(v == 8'h26, "R4 frozen minutes", 64'(v), 64'h26);
        write_reg(0, 8'h00);
        check_time("R4 released view", next_sec(next_sec(next_sec(t0))));

        // R5 write hold
        set_time(t0);
        write_reg(9, 8'h33);
        check_time("R5 write ignored without hold", t0);
        write_reg(0, 8'h02);
        write_reg(9, 8'h44);
        do_tick(); do_tick();
        @(negedge clk);
        addr = BASE; wdata = 8'h00; wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        wr = 1'b0; tick = 1'b0;
        t = t0; t.s = 44;
        check_time("R5 staged load wins over tick", t);

        // R6 stop bit and calibration
        write_reg(8, 8'hFF);
        read_reg(8, v); check(v == 8'hBF, "R6 calibration readback", 64'(v), 64'hBF);
        do_tick(); do_tick(); do_tick();
        check_time("R6 stopped time", t);
        write_reg(8, 8'h15);
        read_reg(8, v); check(v == 8'h15, "R6 calibration value", 64'(v), 64'h15);
        do_tick();
        check_time("R6 running again", next_sec(t));

        // R7 full match
        write_reg(2, 8'h30); write_reg(3, 8'h20); write_reg(4, 8'h10); write_reg(5, 8'h15);
        set_time(mk(20, 25, 5, 15, 2, 10, 20, 29));
        do_tick();
        read_reg(0, v); check(v == 8'h40, "R7 full match sets flag", 64'(v), 64'h40);
        // R8 read clears
        read_reg(0, v); check(v == 8'h00, "R8 flag cleared by read", 64'(v), 64'h00);
        set_time(mk(20, 25, 5, 16, 3, 10, 20, 29));
        do_tick();
        read_reg(0, v); check(v == 8'h00, "R7 date mismatch no flag", 64'(v), 64'h00);

        // R7 single field with others masked
        write_reg(2, 8'h05); write_reg(3, 8'h80); write_reg(4, 8'h80); write_reg(5, 8'h80);
        set_time(mk(20, 25, 5, 16, 3, 11, 42, 3));
        do_tick();
        read_reg(0, v); check(v == 8'h00, "R7 masked no match yet", 64'(v), 64'h00);
        do_tick();
        read_reg(0, v); check(v == 8'h40, "R7 seconds-only match", 64'(v), 64'h40);

        // R9 interrupt
        write_reg(2, 8'h80);
        write_reg(6, 8'h40);
        read_reg(6, v); check(v == 8'h40, "R9 enable readback", 64'(v), 64'h40);
        check(irq == 1'b0, "R9 irq idle", 64'(irq), 64'h0);
        do_tick();
        check(irq == 1'b1, "R9 irq on every-tick alarm", 64'(irq), 64'h1);
        read_reg(0, v);
        check(v == 8'h40, "R7 all masked fires", 64'(v), 64'h40);
        check(irq == 1'b0, "R9 irq drops after flags read", 64'(irq), 64'h0);
        write_reg(6, 8'h00);
        do_tick();
        check(irq == 1'b0, "R9 irq masked by enable", 64'(irq), 64'h0);
        read_reg(0, v); check(v == 8'h40, "R9 flag set without enable", 64'(v), 64'h40);

        // R8 collision: flags read and matching tick in one cycle
        @(negedge clk);
        addr = BASE; rd = 1'b1; tick = 1'b1;
        @(negedge clk);
        rd = 1'b0; tick = 1'b0;
        check(rdata == 8'h00, "R8 collision read returns old flag", 64'(rdata), 64'h00);
        read_reg(0, v); check(v == 8'h40, "R8 collision flag kept", 64'(v), 64'h40);
        write_reg(5, 8'h00);

        // R10 power-fail and watchdog storage
        pwr_fail = 1'b1;
        read_reg(0, v); check(v == 8'h20, "R10 power-fail bit", 64'(v), 64'h20);
        pwr_fail = 1'b0;
        write_reg(7, 8'hA5);
        read_reg(7, v); check(v == 8'hA5, "R10 watchdog storage", 64'(v), 64'hA5);

        // R11 read data holds
        repeat (3) @(negedge clk);
        check(rdata == 8'hA5, "R11 rdata held", 64'(rdata), 64'hA5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule